// File: doc/BRIEF.md
# Gate Pulse Desaturation Fault Logic

This block sits between a PWM command and the gate of a power switch. It forms an effective drive command from a non-inverting and an inverting PWM input, gated by a run enable made from three readiness flags: positive rail, negative rail and internal reference. It registers that command onto the gate output. While the gate is on it watches a digitized desaturation comparator. It ignores the comparator for a fixed blanking window after each turn-on, and during that window it asserts a clamp output that holds the sense node low.

A comparator trip after blanking sets a fault latch. The latch forces the gate off for the rest of the present PWM pulse and emits a one-clock fault event. Protection works cycle by cycle: the latch clears on the next rising edge of the effective command, and the next pulse starts normally. A strap input turns detection off completely. A status output reports the gate as off. When that status and the effective command are both high outside a short mask window after each command edge, an overlap fault flag is raised for half-bridge overlap checking.

Top module: `gate_desat_ctrl`

## Requirements
- R1: The effective command is high only when pwmPos is 1 and pwmNeg is 0. gateOut takes the value of effective command AND run enable one clock after the inputs are applied.
- R2: The run enable is the AND of railHiOk, railLoOk and refOk. When any of the three is 0, gateOut is 0 at the next clock.
- R3: From each gate turn-on, for BLANK_CYC clocks the comparator is ignored and senseClamp is 1. BLANK_CYC is ceil(BLANK_NS/CLK_NS), which is 50 by default. senseClamp is 0 only while the gate is on and blanking has finished.
- R4: After blanking, desatCmp=1 while the gate is on sets faultFlag and turns gateOut off at the next clock. faultEvt is 1 for exactly that one clock.
- R5: faultFlag stays set and gateOut stays off while the effective command remains high. Both clear on the next rising edge of the effective command, and gateOut then turns on at the same clock as in R1.
- R6: While desatOff=1, desatCmp has no effect: no fault is set and the pulse is not shortened.
- R7: gateOffStatus is always the inverse of gateOut.
- R8: overlapFault is a register. It goes to 1 one clock after a cycle in which gateOffStatus and the effective command are both 1 and the mask is not active.
- R9: The overlap check is masked in the cycle in which the effective command differs from its previous value, and for MASK_CYC clocks after that (3 by default).
- R10: After reset, gateOut=0, gateOffStatus=1, faultFlag=0, faultEvt=0 and overlapFault=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| pwmPos | input | 1 | Non-inverting PWM input |
| pwmNeg | input | 1 | Inverting PWM input |
| railHiOk | input | 1 | Positive gate rail ready |
| railLoOk | input | 1 | Negative gate rail ready |
| refOk | input | 1 | Internal reference ready |
| desatCmp | input | 1 | Digitized desaturation comparator output |
| desatOff | input | 1 | Strap: 1 disables desaturation detection |
| gateOut | output | 1 | Gate command to the power stage |
| senseClamp | output | 1 | Holds the sense node low during blanking and off time |
| faultFlag | output | 1 | Desaturation fault latch |
| faultEvt | output | 1 | One-clock pulse when a fault is detected |
| gateOffStatus | output | 1 | High whenever the gate is off |
| overlapFault | output | 1 | Status and effective command both high outside the mask |

## Verification
The input qualification is driven with every relevant mix of the two PWM inputs and the three readiness flags. This separates the inverting-input veto from each single missing ready flag. The desaturation path is tried with four patterns: a comparator held high across a full pulse, which shows the exact end of blanking and the one-clock cut; a pulse shorter than blanking; a tripping comparator with the strap set; and a comparator high while the gate is off. Re-arming is shown by keeping the command high after a fault and then raising it again. The overlap flag is provoked both inside and after the mask window, by a rail dropping mid-pulse and by a command rising while a rail is absent.

// File: rtl/gdc_pkg.sv
package gdc_pkg;

  // Strobes from the control section to the datapath
  typedef struct packed {
    logic cutGate;      // force gate off this cycle
    logic maskOverlap;  // suppress overlap compare this cycle
    logic senseClamp;   // hold sense node low
  } ctrlStrobe_t;

  function automatic int ceilDiv(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

endpackage

// File: rtl/gdc_path.sv
module gdc_path
  import gdc_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        pwmPos,
  input  logic        pwmNeg,
  input  logic        railHiOk,
  input  logic        railLoOk,
  input  logic        refOk,
  input  ctrlStrobe_t strobe,
  output logic        cmdRise,
  output logic        cmdEdge,
  output logic        gateOn,
  output logic        gateOffStatus,
  output logic        overlapFault
);

  logic cmd;
  logic cmdQ;
  logic runOk;
  logic gateQ;
  logic ovlQ;

  assign cmd     = pwmPos & ~pwmNeg;
  assign runOk   = railHiOk & railLoOk & refOk;
  assign cmdRise = cmd & ~cmdQ;
  assign cmdEdge = cmd ^ cmdQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdQ  <= 1'b0;
      gateQ <= 1'b0;
      ovlQ  <= 1'b0;
    end else begin
      cmdQ  <= cmd;
      gateQ <= cmd & runOk & ~strobe.cutGate;
      ovlQ  <= ~gateQ & cmd & ~strobe.maskOverlap;
    end
  end

  assign gateOn        = gateQ;
  assign gateOffStatus = ~gateQ;
  assign overlapFault  = ovlQ;

  // R1: no effective command means the gate is off one clock later
  assert_cmd_gate_R1: assert property (@(posedge clk) disable iff (!rstN)
    (!pwmPos || pwmNeg) |=> !gateOn);

  // R2: a missing ready flag means the gate is off one clock later
  assert_run_gate_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!railHiOk || !railLoOk || !refOk) |=> !gateOn);

  // R4: a cut strobe from control turns the gate off
  assert_cut_gate_R4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.cutGate |=> !gateOn);

endmodule

// File: rtl/gdc_ctrl.sv
module gdc_ctrl
  import gdc_pkg::*;
#(
  parameter int BLANK_CYC = 50,
  parameter int MASK_CYC  = 3
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        cmdRise,
  input  logic        cmdEdge,
  input  logic        gateOn,
  input  logic        desatCmp,
  input  logic        desatOff,
  output ctrlStrobe_t strobe,
  output logic        faultFlag,
  output logic        faultEvt
);

  localparam int BW = $clog2(BLANK_CYC + 1);
  localparam int MW = $clog2(MASK_CYC + 1);
  localparam logic [BW-1:0] BLANK_END = BW'(BLANK_CYC);
  localparam logic [MW-1:0] MASK_LOAD = MW'(MASK_CYC);

  logic [BW-1:0] blankCnt;
  logic [MW-1:0] maskCnt;
  logic          blankDone;
  logic          detect;
  logic          faultQ;
  logic          evtQ;

  assign blankDone = (blankCnt == BLANK_END);
  assign detect    = gateOn & blankDone & desatCmp & ~desatOff;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      blankCnt <= '0;
    end else if (!gateOn) begin
      blankCnt <= '0;
    end else if (!blankDone) begin
      blankCnt <= blankCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      faultQ <= 1'b0;
      evtQ   <= 1'b0;
    end else begin
      faultQ <= (faultQ & ~cmdRise) | detect;
      evtQ   <= detect;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      maskCnt <= '0;
    end else if (cmdEdge) begin
      maskCnt <= MASK_LOAD;
    end else if (maskCnt != '0) begin
      maskCnt <= maskCnt - 1'b1;
    end
  end

  assign strobe.cutGate     = (faultQ & ~cmdRise) | detect;
  assign strobe.maskOverlap = cmdEdge | (maskCnt != '0);
  assign strobe.senseClamp  = ~(gateOn & blankDone);

  assign faultFlag = faultQ;
  assign faultEvt  = evtQ;

  // R3: the sense clamp is active in the first cycle of every pulse
  assert_blank_start_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(gateOn) |-> strobe.senseClamp);

  // R4: a new fault needs a live gate and a tripped comparator
  assert_fault_src_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(faultFlag) |-> ($past(gateOn) && $past(desatCmp)));

  // R4: the fault event lasts one clock
  assert_evt_pulse_R4: assert property (@(posedge clk) disable iff (!rstN)
    faultEvt |=> !faultEvt);

  // R5: the latch clears only on a command rising edge
  assert_fault_clear_R5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(faultFlag) |-> $past(cmdRise));

  // R6: the strap blocks every fault event
  assert_strap_off_R6: assert property (@(posedge clk) disable iff (!rstN)
    faultEvt |-> !$past(desatOff));

endmodule

// File: rtl/gate_desat_ctrl.sv
module gate_desat_ctrl #(
  parameter int CLK_NS   = 10,
  parameter int BLANK_NS = 500,
  parameter int MASK_CYC = 3
) (
  input  logic clk,
  input  logic rstN,
  input  logic pwmPos,
  input  logic pwmNeg,
  input  logic railHiOk,
  input  logic railLoOk,
  input  logic refOk,
  input  logic desatCmp,
  input  logic desatOff,
  output logic gateOut,
  output logic senseClamp,
  output logic faultFlag,
  output logic faultEvt,
  output logic gateOffStatus,
  output logic overlapFault
);

  localparam int BLANK_CYC = gdc_pkg::ceilDiv(BLANK_NS, CLK_NS);

  gdc_pkg::ctrlStrobe_t strobe;
  logic cmdRise;
  logic cmdEdge;
  logic gateOn;

  gdc_path i_path (
    .clk          (clk),
    .rstN         (rstN),
    .pwmPos       (pwmPos),
    .pwmNeg       (pwmNeg),
    .railHiOk     (railHiOk),
    .railLoOk     (railLoOk),
    .refOk        (refOk),
    .strobe       (strobe),
    .cmdRise      (cmdRise),
    .cmdEdge      (cmdEdge),
    .gateOn       (gateOn),
    .gateOffStatus(gateOffStatus),
    .overlapFault (overlapFault)
  );

  gdc_ctrl #(
    .BLANK_CYC(BLANK_CYC),
    .MASK_CYC (MASK_CYC)
  ) i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .cmdRise  (cmdRise),
    .cmdEdge  (cmdEdge),
    .gateOn   (gateOn),
    .desatCmp (desatCmp),
    .desatOff (desatOff),
    .strobe   (strobe),
    .faultFlag(faultFlag),
    .faultEvt (faultEvt)
  );

  assign gateOut    = gateOn;
  assign senseClamp = strobe.senseClamp;

  // R7: status is the complement of the gate
  assert_status_inv_R7: assert property (@(posedge clk) disable iff (!rstN)
    gateOffStatus != gateOut);

endmodule

// File: tb/test_gate_desat_ctrl.sv
module test_gate_desat_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int BLANK      = 50;
  localparam int MASK       = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic pwmPos = 1'b0, pwmNeg = 1'b0;
  logic railHiOk = 1'b1, railLoOk = 1'b1, refOk = 1'b1;
  logic desatCmp = 1'b0, desatOff = 1'b0;
  logic gateOut, senseClamp, faultFlag, faultEvt, gateOffStatus, overlapFault;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gate_desat_ctrl #(.CLK_NS(CLK_PERIOD), .BLANK_NS(500), .MASK_CYC(MASK)) i_gate_desat_ctrl (
    .clk(clk), .rstN(rstN), .pwmPos(pwmPos), .pwmNeg(pwmNeg),
    .railHiOk(railHiOk), .railLoOk(railLoOk), .refOk(refOk),
    .desatCmp(desatCmp), .desatOff(desatOff),
    .gateOut(gateOut), .senseClamp(senseClamp), .faultFlag(faultFlag),
    .faultEvt(faultEvt), .gateOffStatus(gateOffStatus), .overlapFault(overlapFault)
  );

  // {pwmPos, pwmNeg, railHiOk, railLoOk, refOk, expected gate}
  localparam logic [5:0] VEC [8] = '{
    6'b10111_1, 6'b11111_0, 6'b00111_0, 6'b01111_0,
    6'b10011_0, 6'b10101_0, 6'b10110_0, 6'b10111_1
  };

  task automatic check(input string req, input string what, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%b expected=%b at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    tick(2);
    // R10: reset state
    check("R10", "gateOut", gateOut, 1'b0);
    check("R10", "gateOffStatus", gateOffStatus, 1'b1);
    check("R10", "faultFlag", faultFlag, 1'b0);
    check("R10", "faultEvt", faultEvt, 1'b0);
    check("R10", "overlapFault", overlapFault, 1'b0);
    rstN = 1'b1;
    tick(2);

    // Vector table: R1 and R2 input qualification, R7 status
    for (int i = 0; i < 8; i++) begin
      {pwmPos, pwmNeg, railHiOk, railLoOk, refOk} = VEC[i][5:1];
      tick(1);
      check((VEC[i][3:1] == 3'b111) ? "R1" : "R2", "gateOut", gateOut, VEC[i][0]);
      check("R7", "gateOffStatus", gateOffStatus, ~VEC[i][0]);
    end
    {pwmPos, pwmNeg, railHiOk, railLoOk, refOk} = 5'b00111;
    tick(MASK + 3);

    // R3/R4: comparator high across the whole pulse
    desatCmp = 1'b1;
    pwmPos = 1'b1;
    tick(BLANK);
    check("R3", "senseClamp last blank cycle", senseClamp, 1'b1);
    check("R3", "gate during blanking", gateOut, 1'b1);
    check("R3", "no fault during blanking", faultFlag, 1'b0);
    tick(1);
    check("R3", "senseClamp after blanking", senseClamp, 1'b0);
    check("R4", "gate before cut", gateOut, 1'b1);
    tick(1);
    check("R4", "gate cut", gateOut, 1'b0);
    check("R4", "faultFlag", faultFlag, 1'b1);
    check("R4", "faultEvt", faultEvt, 1'b1);
    check("R7", "status after cut", gateOffStatus, 1'b1);
    tick(1);
    check("R4", "faultEvt single", faultEvt, 1'b0);
    check("R5", "fault held with command high", faultFlag, 1'b1);
    check("R8", "overlap after cut", overlapFault, 1'b1);
    desatCmp = 1'b0;
    tick(5);
    check("R5", "gate stays off", gateOut, 1'b0);
    pwmPos = 1'b0;
    tick(1);
    check("R5", "fault held after command low", faultFlag, 1'b1);
    check("R8", "overlap clears", overlapFault, 1'b0);
    tick(3);
    pwmPos = 1'b1;
    tick(1);
    check("R5", "fault cleared on rise", faultFlag, 1'b0);
    check("R5", "next pulse starts", gateOut, 1'b1);
    tick(BLANK + 10);
    check("R5", "fresh pulse held", gateOut, 1'b1);
    pwmPos = 1'b0;
    tick(MASK + 3);

    // R3: pulse shorter than blanking with comparator high
    desatCmp = 1'b1;
    pwmPos = 1'b1;
    tick(BLANK - 10);
    pwmPos = 1'b0;
    tick(2);
    check("R3", "short pulse no fault", faultFlag, 1'b0);

    // Comparator high with gate off
    tick(BLANK + 5);
    check("R4", "gate off no fault", faultFlag, 1'b0);

    // R6: strap disables detection
    desatOff = 1'b1;
    pwmPos = 1'b1;
    tick(BLANK + 20);
    check("R6", "gate not cut", gateOut, 1'b1);
    check("R6", "no fault", faultFlag, 1'b0);
    check("R6", "no event", faultEvt, 1'b0);
    pwmPos = 1'b0;
    desatOff = 1'b0;
    desatCmp = 1'b0;
    tick(MASK + 3);

    // R2/R8: ready flag drops mid-pulse
    pwmPos = 1'b1;
    tick(10);
    refOk = 1'b0;
    tick(1);
    check("R2", "gate off on refOk low", gateOut, 1'b0);
    check("R8", "overlap not yet", overlapFault, 1'b0);
    tick(1);
    check("R8", "overlap raised", overlapFault, 1'b1);
    pwmPos = 1'b0;
    tick(MASK + 3);
    check("R8", "overlap idle", overlapFault, 1'b0);

    // R9: command rises while rail missing, mask window
    pwmPos = 1'b1;
    tick(MASK + 1);
    check("R9", "overlap masked", overlapFault, 1'b0);
    tick(1);
    check("R9", "overlap after mask", overlapFault, 1'b1);
    pwmPos = 1'b0;
    refOk = 1'b1;
    tick(MASK + 3);

    finish_run();
  end

endmodule